// File: doc/BRIEF.md
# Slotted Burst Channel Scheduler

This block assigns data bursts to the wavelength channels of one output port in a slotted optical burst switch. Time is counted in whole slots, and a global slot counter arrives as an input. Requests come one at a time from a destination queue over a valid/ready handshake. Each request carries an arrival slot stamp, an offset, a length in slots and a one-bit priority. From these the block works out the slots in which the burst starts and ends. It compares those slots with the reservation that each channel holds, then returns one decision per request: accept on a given channel, or drop. It also returns a flag for displacing a weaker reservation, and the fields of the outgoing burst header.

Each channel keeps its horizon, which is the end slot of its last reservation. It also keeps the horizon that stood before that reservation, and the start, length and priority of that reservation. A free channel is chosen by the latest-available rule: the free channel whose horizon lies closest below the new start wins. When every channel is busy, a high-priority burst may displace the shortest low-priority reservation that has not yet begun. It may do so only if the channel is then clear from the new start slot onward. Each decision appears on the outputs in the cycle after the handshake.

Top module: `burst_chan_sched`

## Requirements
- R1: The start slot is stamp plus offset, and the end slot is start plus length. An accepted burst's header carries offset = start minus the current slot, together with the request's length and priority.
- R2: A channel counts as free when its horizon is at or below the current slot (expired, taken as horizon 0) or at or below the start slot. Among the free channels, the one with the largest such horizon is chosen; a tie goes to the lowest index.
- R3: Accepting a burst sets that channel's horizon to the end slot. A later burst that starts before this horizon is never placed on that channel without displacing it.
- R4: A low-priority burst that finds no free channel is dropped.
- R5: A high-priority burst that finds no free channel may displace a reservation. The reservation must be low priority, its start slot must be later than the current slot, and its channel's prior horizon must be at or below the new start. The shortest such reservation is chosen (tie: lowest index), and the burst is accepted with the preempt flag set. If no reservation qualifies, the burst is dropped.
- R6: A request of length 0, or one whose start slot is earlier than the current slot, is dropped without touching any channel.
- R7: Each handshake (valid and ready both high at a clock edge) produces exactly one decision pulse in the next cycle, with exactly one of accept and drop set. Without a handshake, no decision is given.
- R8: The header-valid output is high only with an accept. After a drop, channel, offset, length, priority and preempt are all zero.
- R9: While reset is held, ready and every decision output are low and all channels are free. Ready rises at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_now | input | TW | Global slot counter |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request |
| req_ts | input | TW | Arrival slot stamp |
| req_off | input | OFFW | Offset in slots |
| req_len | input | LENW | Burst length in slots |
| req_prio | input | 1 | Priority, 1 = high |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Burst reserved |
| dec_drop | output | 1 | Burst dropped |
| dec_chan | output | CW | Chosen channel index |
| dec_preempt | output | 1 | A low-priority reservation was displaced |
| hdr_valid | output | 1 | Regenerated header present |
| hdr_off | output | TW | Header offset from the current slot |
| hdr_len | output | LENW | Header length |
| hdr_prio | output | 1 | Header priority |

## Verification
On every cycle, the checker enforces the following: the one-to-one link between handshakes and decision pulses, that accept and drop exclude each other, that a header is tied to an accept, that a preemption comes only from a high-priority accept, and that a drop leaves zeroed fields. Which channel is chosen depends on the stored horizons, so only the bench's scenarios can show it. This covers the latest-horizon choice, the lowest-index tie-break, the choice of the shortest low-priority victim, and refusal when the prior horizon overlaps the new start. Directed scenarios fill the channels and exercise each kind of preemption, and a long swept stream compares every decision with an arithmetic model of the channel records.

// File: rtl/burst_chan_sched.sv
module burst_chan_sched #(
  parameter int NCH  = 4,
  parameter int TW   = 12,
  parameter int OFFW = 5,
  parameter int LENW = 4,
  localparam int CW  = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   slot_now,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [TW-1:0]   req_ts,
  input  logic [OFFW-1:0] req_off,
  input  logic [LENW-1:0] req_len,
  input  logic            req_prio,
  output logic            dec_valid,
  output logic            dec_accept,
  output logic            dec_drop,
  output logic [CW-1:0]   dec_chan,
  output logic            dec_preempt,
  output logic            hdr_valid,
  output logic [TW-1:0]   hdr_off,
  output logic [LENW-1:0] hdr_len,
  output logic            hdr_prio
);

  logic [TW-1:0]   hz [NCH];
  logic [TW-1:0]   ph [NCH];
  logic [TW-1:0]   rs [NCH];
  logic [LENW-1:0] rl [NCH];
  logic [NCH-1:0]  rp;

  logic [TW-1:0]   eh [NCH];
  logic [NCH-1:0]  fr, cand;

  logic [TW-1:0] st, en;
  assign st = req_ts + TW'(req_off);
  assign en = st + TW'(req_len);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign eh[i]   = (hz[i] <= slot_now) ? '0 : hz[i];
    assign fr[i]   = eh[i] <= st;
    assign cand[i] = !rp[i] && (hz[i] > slot_now) && (rs[i] > slot_now) && (ph[i] <= st);
  end

  logic            f_ok, c_ok;
  logic [CW-1:0]   f_idx, c_idx;
  logic [TW-1:0]   f_h;
  logic [LENW-1:0] c_len;

  always_comb begin
    f_ok = 1'b0; f_idx = '0; f_h = '0;
    c_ok = 1'b0; c_idx = '0; c_len = '1;
    for (int i = 0; i < NCH; i++) begin
      if (fr[i] && (!f_ok || eh[i] > f_h)) begin
        f_ok = 1'b1; f_idx = CW'(i); f_h = eh[i];
      end
      if (cand[i] && (!c_ok || rl[i] < c_len)) begin
        c_ok = 1'b1; c_idx = CW'(i); c_len = rl[i];
      end
    end
  end

  logic bad, pre, acc, fire, take;
  logic [CW-1:0] sel;
  assign bad  = (req_len == '0) || (st < slot_now);
  assign pre  = !bad && !f_ok && req_prio && c_ok;
  assign acc  = !bad && (f_ok || pre);
  assign sel  = f_ok ? f_idx : c_idx;
  assign fire = req_valid && req_ready;
  assign take = fire && acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready   <= 1'b0;
      dec_valid   <= 1'b0;
      dec_accept  <= 1'b0;
      dec_drop    <= 1'b0;
      dec_chan    <= '0;
      dec_preempt <= 1'b0;
      hdr_valid   <= 1'b0;
      hdr_off     <= '0;
      hdr_len     <= '0;
      hdr_prio    <= 1'b0;
      rp          <= '0;
      for (int i = 0; i < NCH; i++) begin
        hz[i] <= '0; ph[i] <= '0; rs[i] <= '0; rl[i] <= '0;
      end
    end else begin
      req_ready   <= 1'b1;
      dec_valid   <= fire;
      dec_accept  <= take;
      dec_drop    <= fire && !acc;
      dec_preempt <= fire && pre;
      dec_chan    <= take ? sel : '0;
      hdr_valid   <= take;
      hdr_off     <= take ? st - slot_now : '0;
      hdr_len     <= take ? req_len : '0;
      hdr_prio    <= take && req_prio;
      if (take) begin
        if (!pre) ph[sel] <= hz[sel];
        hz[sel] <= en;
        rs[sel] <= st;
        rl[sel] <= req_len;
        rp[sel] <= req_prio;
      end
    end
  end

endmodule

module chk_burst_chan_sched #(
  parameter int TW   = 12,
  parameter int LENW = 4,
  parameter int CW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            dec_valid,
  input logic            dec_accept,
  input logic            dec_drop,
  input logic [CW-1:0]   dec_chan,
  input logic            dec_preempt,
  input logic            hdr_valid,
  input logic [TW-1:0]   hdr_off,
  input logic [LENW-1:0] hdr_len,
  input logic            hdr_prio
);
  AST_FIRE_DECIDES:  assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> dec_valid); // R7
  AST_NO_IDLE_DEC:   assert property (@(posedge clk) disable iff (!rst_n) !(req_valid && req_ready) |=> !dec_valid); // R7
  AST_ONE_OUTCOME:   assert property (@(posedge clk) disable iff (!rst_n) dec_valid |-> (dec_accept ^ dec_drop)); // R7
  AST_HDR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) hdr_valid == (dec_valid && dec_accept)); // R8
  AST_DROP_ZEROED:   assert property (@(posedge clk) disable iff (!rst_n) dec_drop |-> (hdr_off == '0 && hdr_len == '0 && !hdr_prio && dec_chan == '0 && !dec_preempt)); // R8
  AST_PREEMPT_HIGH:  assert property (@(posedge clk) disable iff (!rst_n) dec_preempt |-> (dec_accept && hdr_prio)); // R5
  AST_ACCEPT_LEN:    assert property (@(posedge clk) disable iff (!rst_n) dec_accept |-> hdr_len != '0); // R6
  AST_RESET_QUIET:   assert property (@(posedge clk) !rst_n |-> (!req_ready && !dec_valid)); // R9
endmodule

bind burst_chan_sched chk_burst_chan_sched #(.TW(TW), .LENW(LENW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_drop(dec_drop),
  .dec_chan(dec_chan), .dec_preempt(dec_preempt), .hdr_valid(hdr_valid),
  .hdr_off(hdr_off), .hdr_len(hdr_len), .hdr_prio(hdr_prio)
);

// File: tb/tb_burst_chan_sched.sv
module tb_burst_chan_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4, TW = 12, OFFW = 5, LENW = 4, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] slot_now = '0, req_ts = '0;
  logic req_valid = 1'b0, req_ready, req_prio = 1'b0;
  logic [OFFW-1:0] req_off = '0;
  logic [LENW-1:0] req_len = '0;
  logic dec_valid, dec_accept, dec_drop, dec_preempt, hdr_valid, hdr_prio;
  logic [CW-1:0] dec_chan;
  logic [TW-1:0] hdr_off;
  logic [LENW-1:0] hdr_len;

  burst_chan_sched #(.NCH(NCH), .TW(TW), .OFFW(OFFW), .LENW(LENW)) dut (
    .clk(clk), .rst_n(rst_n), .slot_now(slot_now), .req_valid(req_valid), .req_ready(req_ready),
    .req_ts(req_ts), .req_off(req_off), .req_len(req_len), .req_prio(req_prio),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_drop(dec_drop), .dec_chan(dec_chan),
    .dec_preempt(dec_preempt), .hdr_valid(hdr_valid), .hdr_off(hdr_off), .hdr_len(hdr_len),
    .hdr_prio(hdr_prio));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int s = 10;
  int m_hz[NCH], m_ph[NCH], m_rs[NCH], m_rl[NCH], m_rp[NCH];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send(int ts, int off, int len, int prio);
    int st, en, fi, fh, ci, cl, eh, ch;
    bit bad, pre, acc;
    string tag;
    @(negedge clk);
    slot_now = TW'(s); req_ts = TW'(ts); req_off = OFFW'(off);
    req_len = LENW'(len); req_prio = prio[0]; req_valid = 1'b1;
    st = ts + off; en = st + len;
    bad = (len == 0) || (st < s);
    fi = -1; fh = 0; ci = -1; cl = 0;
    for (int i = 0; i < NCH; i++) begin
      eh = (m_hz[i] <= s) ? 0 : m_hz[i];
      if (eh <= st && (fi < 0 || eh > fh)) begin fi = i; fh = eh; end
      if (m_rp[i] == 0 && m_hz[i] > s && m_rs[i] > s && m_ph[i] <= st && (ci < 0 || m_rl[i] < cl)) begin
        ci = i; cl = m_rl[i];
      end
    end
    pre = !bad && fi < 0 && prio != 0 && ci >= 0;
    acc = !bad && (fi >= 0 || pre);
    ch  = acc ? ((fi >= 0) ? fi : ci) : 0;
    tag = bad ? "R6" : (pre || (!acc && prio != 0)) ? "R5" : !acc ? "R4" : "R2";
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7", "dec_valid", int'(dec_valid), 1);
    chk(tag, "accept", int'(dec_accept), int'(acc));
    chk("R7", "drop", int'(dec_drop), int'(!acc));
    chk(tag, "channel", int'(dec_chan), ch);
    chk(tag, "preempt", int'(dec_preempt), int'(pre));
    chk("R8", "hdr_valid", int'(hdr_valid), int'(acc));
    chk("R1", "hdr_off", int'(hdr_off), acc ? st - s : 0);
    chk("R1", "hdr_len", int'(hdr_len), acc ? len : 0);
    chk("R1", "hdr_prio", int'(hdr_prio), acc ? prio : 0);
    if (acc) begin
      if (!pre) m_ph[ch] = m_hz[ch];
      m_hz[ch] = en; m_rs[ch] = st; m_rl[ch] = len; m_rp[ch] = prio;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r;
    for (int i = 0; i < NCH; i++) begin m_hz[i] = 0; m_ph[i] = 0; m_rs[i] = 0; m_rl[i] = 0; m_rp[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R9", "ready in reset", int'(req_ready), 0);
    chk("R9", "dec_valid in reset", int'(dec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "ready after reset", int'(req_ready), 1);
    @(negedge clk);
    chk("R7", "no decision when idle", int'(dec_valid), 0);

    send(10, 2, 3, 0);  chk("R2", "first on ch0", int'(dec_chan), 0);
    chk("R1", "offset 2", int'(hdr_off), 2);
    send(10, 2, 3, 0);  chk("R3", "overlap to ch1", int'(dec_chan), 1);
    send(10, 20, 2, 0); chk("R2", "latest horizon tie ch0", int'(dec_chan), 0);
    send(10, 3, 4, 0);  chk("R2", "ch2", int'(dec_chan), 2);
    send(10, 3, 5, 0);  chk("R2", "ch3", int'(dec_chan), 3);
    send(10, 3, 2, 0);  chk("R4", "low dropped", int'(dec_drop), 1);
    send(10, 3, 2, 1);  chk("R5", "shortest victim ch1", int'(dec_chan), 1);
    chk("R5", "preempt flag", int'(dec_preempt), 1);
    send(10, 3, 2, 1);  chk("R5", "victim ch2", int'(dec_chan), 2);
    send(10, 3, 2, 1);  chk("R5", "victim ch3", int'(dec_chan), 3);
    send(10, 3, 2, 1);  chk("R5", "no victim drop", int'(dec_drop), 1);
    send(10, 3, 0, 1);  chk("R6", "zero length drop", int'(dec_drop), 1);
    send(5, 1, 3, 1);   chk("R6", "late start drop", int'(dec_drop), 1);
    chk("R8", "drop zero len", int'(hdr_len), 0);

    r = 12345;
    for (int n = 0; n < 1500; n++) begin
      r = r * 1103515245 + 12345;
      s = s + ((r >>> 16) & 32'h7fff) % 3;
      r = r * 1103515245 + 12345;
      begin
        int v;
        v = (r >>> 16) & 32'h7fff;
        send(s - v % 4, (v >> 2) % 32, (v >> 7) % 16, (v >> 11) & 1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule